// File: doc/BRIEF.md
# FIFO Trigger Level Controller

This block holds a pair of byte queues for a serial port, one on the transmit side and one on the receive side, each 32 entries deep. It tracks how full each queue is and compares the fill count against a trigger threshold for that side. The result is two request lines: a transmit-ready request, which asks for more data while the transmit queue is low, and a receive-data request, which reports that the receive queue has filled to its threshold.

Software configures the block through an 8-bit control word. One bit selects between queue mode and single-byte holding mode. Two self-clearing bits empty the queues. Two 2-bit fields choose the thresholds. The receive threshold takes effect as soon as it is written. The transmit threshold is stored when written, but it is applied only while the enhanced-threshold input is high. While that input is low, the transmit side uses a fixed threshold of 16.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: After a synchronous reset, the block is in holding mode. Both counts are 0, `tx_req` is 1, `rx_req` is 0, both overrun flags are 0 and both data outputs are 0.
- R2: A control write with bit 0 = 1 selects queue mode (capacity 32), and bit 0 = 0 selects holding mode (capacity 1). A write that changes bit 0 empties both queues and clears both overrun flags.
- R3: Bytes leave each queue in the order they entered. A pop of a non-empty queue places the oldest byte on the data output after the clock edge, and the count is updated at that same edge.
- R4: In queue mode the receive threshold comes from control bits 7:6, with codes 00, 01, 10 and 11 giving 8, 16, 24 and 28. `rx_req` is 1 while the receive count is at or above that threshold.
- R5: Control bits 5:4 store a transmit threshold code with the same mapping as R4. In queue mode, `tx_req` is 1 while the transmit count is at or below the active threshold. The active threshold is the stored code while `enh_tx_trig` is 1, and 16 while it is 0.
- R6: Both requests are registered. Each one reflects the count after the current edge, compared against the mode and thresholds in force before that edge.
- R7: In holding mode, `tx_req` is 1 exactly when the transmit holding byte is empty, and `rx_req` is 1 exactly when the receive holding byte is occupied.
- R8: Control bit 1 empties only the receive queue and clears only `rx_ovr`. Control bit 2 does the same for the transmit queue and `tx_ovr`. Neither bit is stored, and a flush takes priority over a push or pop in the same cycle.
- R9: A push to a full queue is dropped, leaves the count and contents unchanged, and sets that side's overrun flag. The flag stays set until that queue is flushed.
- R10: A pop from an empty queue leaves the count at 0 and the data output at its previous value.
- R11: With push and pop in the same cycle, a queue that is neither full nor empty keeps its count. A full queue drops the push (setting its overrun flag) and loses one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fcr_wr | input | 1 | Control word write strobe |
| fcr_data | input | 8 | Control word: bit0 mode, bit1 rx flush, bit2 tx flush, bits5:4 tx code, bits7:6 rx code |
| enh_tx_trig | input | 1 | Applies the stored transmit threshold when high |
| tx_push | input | 1 | Write a byte into the transmit queue |
| tx_din | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Take the oldest transmit byte |
| tx_dout | output | 8 | Last byte popped from the transmit queue |
| tx_count | output | 6 | Transmit fill count |
| tx_req | output | 1 | Transmit-ready request |
| tx_ovr | output | 1 | Transmit overrun flag |
| rx_push | input | 1 | Write a byte into the receive queue |
| rx_din | input | 8 | Receive byte in |
| rx_pop | input | 1 | Take the oldest receive byte |
| rx_dout | output | 8 | Last byte popped from the receive queue |
| rx_count | output | 6 | Receive fill count |
| rx_req | output | 1 | Receive-data request |
| rx_ovr | output | 1 | Receive overrun flag |

## Verification
The hardest states to reach from the ports are the full queue and the 28-entry thresholds, because any stray flush or mode change throws away the fill built up over dozens of cycles. The random stimulus therefore runs in phases, alternating between push-heavy and pop-heavy periods, and mostly keeps control writes at the same mode with the flush bits clear. A directed pass then fills the transmit side past 32 with the enhanced input low and then high, so the stored code and the fixed 16 can each be told apart from the other.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

  // control word field positions
  localparam int CW_MODE_BIT  = 0;
  localparam int CW_RXCLR_BIT = 1;
  localparam int CW_TXCLR_BIT = 2;
  localparam int CW_TXTRG_LSB = 4;
  localparam int CW_RXTRG_LSB = 6;

  typedef struct packed {
    logic       qmode;
    logic [1:0] rx_code;
    logic [1:0] tx_code;
  } trig_cfg_t;

  // threshold from a 2-bit code, scaled by queue depth
  function automatic int unsigned trig_level(input logic [1:0] code, input int unsigned depth);
    case (code)
      2'd0:    return depth / 4;
      2'd1:    return depth / 2;
      2'd2:    return (3 * depth) / 4;
      default: return depth - depth / 8;
    endcase
  endfunction

endpackage

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg
  import fifo_trig_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [7:0]      data,
  output trig_cfg_t       cfg,
  output logic            rx_flush,
  output logic            tx_flush
);

  logic mode_change;

  assign mode_change = data[CW_MODE_BIT] != cfg.qmode;
  assign rx_flush    = wr & (data[CW_RXCLR_BIT] | mode_change);
  assign tx_flush    = wr & (data[CW_TXCLR_BIT] | mode_change);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.qmode   <= 1'b0;
      cfg.rx_code <= 2'd0;
      cfg.tx_code <= 2'd1;
    end else if (wr) begin
      cfg.qmode   <= data[CW_MODE_BIT];
      cfg.rx_code <= data[CW_RXTRG_LSB +: 2];
      cfg.tx_code <= data[CW_TXTRG_LSB +: 2];
    end
  end

endmodule

// File: rtl/trig_level_sel.sv
module trig_level_sel
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  trig_cfg_t       cfg,
  input  logic            enh,
  output logic [CW-1:0]   tx_level,
  output logic [CW-1:0]   rx_level
);

  localparam int unsigned TX_FIXED = DEPTH / 2;

  always_comb begin
    rx_level = CW'(trig_level(cfg.rx_code, DEPTH));
    if (enh) tx_level = CW'(trig_level(cfg.tx_code, DEPTH));
    else     tx_level = CW'(TX_FIXED);
  end

endmodule

// File: rtl/trig_fifo.sv
module trig_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter bit IS_TX = 1'b1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            holding,
  input  logic [CW-1:0]   level,
  input  logic            push,
  input  logic [DW-1:0]   din,
  input  logic            pop,
  output logic [DW-1:0]   dout,
  output logic [CW-1:0]   count,
  output logic            req,
  output logic            ovr
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap, cnt_nxt;
  logic          full, empty, do_push, do_pop, req_nxt;

  assign cap     = holding ? CW'(1) : CW'(DEPTH);
  assign full    = count == cap;
  assign empty   = count == '0;
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;

  always_comb begin
    if (flush) cnt_nxt = '0;
    else       cnt_nxt = count + CW'(do_push) - CW'(do_pop);
  end

  generate
    if (IS_TX) begin : g_tx_cmp
      assign req_nxt = holding ? (cnt_nxt == '0) : (cnt_nxt <= level);
    end else begin : g_rx_cmp
      assign req_nxt = holding ? (cnt_nxt != '0) : (cnt_nxt >= level);
    end
  endgenerate

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (do_pop) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      req   <= IS_TX;
      ovr   <= 1'b0;
    end else begin
      count <= cnt_nxt;
      req   <= req_nxt;
      if (flush)             ovr <= 1'b0;
      else if (push && full) ovr <= 1'b1;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r7_holding_bound: assert property (@(posedge clk) disable iff (rst)
    holding |-> count <= CW'(1));

  a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (!flush && push && !pop && full) |=> (count == $past(count)) && ovr);

  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr && !flush) |=> ovr);

  a_r10_empty_pop_holds: assert property (@(posedge clk) disable iff (rst)
    (!flush && pop && !push && empty) |=> $stable(dout) && (count == '0));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0) && !ovr);

endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
  import fifo_trig_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fcr_wr,
  input  logic [7:0]                   fcr_data,
  input  logic                         enh_tx_trig,
  input  logic                         tx_push,
  input  logic [DW-1:0]                tx_din,
  input  logic                         tx_pop,
  output logic [DW-1:0]                tx_dout,
  output logic [$clog2(DEPTH+1)-1:0]   tx_count,
  output logic                         tx_req,
  output logic                         tx_ovr,
  input  logic                         rx_push,
  input  logic [DW-1:0]                rx_din,
  input  logic                         rx_pop,
  output logic [DW-1:0]                rx_dout,
  output logic [$clog2(DEPTH+1)-1:0]   rx_count,
  output logic                         rx_req,
  output logic                         rx_ovr
);

  localparam int CW = $clog2(DEPTH + 1);

  trig_cfg_t     cfg;
  logic          rx_flush, tx_flush;
  logic [CW-1:0] tx_level, rx_level;

  trig_cfg_reg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr       (fcr_wr),
    .data     (fcr_data),
    .cfg      (cfg),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  trig_level_sel #(.DEPTH(DEPTH)) u_lvl (
    .cfg      (cfg),
    .enh      (enh_tx_trig),
    .tx_level (tx_level),
    .rx_level (rx_level)
  );

  trig_fifo #(.DEPTH(DEPTH), .DW(DW), .IS_TX(1'b1)) u_txq (
    .clk     (clk),
    .rst     (rst),
    .flush   (tx_flush),
    .holding (~cfg.qmode),
    .level   (tx_level),
    .push    (tx_push),
    .din     (tx_din),
    .pop     (tx_pop),
    .dout    (tx_dout),
    .count   (tx_count),
    .req     (tx_req),
    .ovr     (tx_ovr)
  );

  trig_fifo #(.DEPTH(DEPTH), .DW(DW), .IS_TX(1'b0)) u_rxq (
    .clk     (clk),
    .rst     (rst),
    .flush   (rx_flush),
    .holding (~cfg.qmode),
    .level   (rx_level),
    .push    (rx_push),
    .din     (rx_din),
    .pop     (rx_pop),
    .dout    (rx_dout),
    .count   (rx_count),
    .req     (rx_req),
    .ovr     (rx_ovr)
  );

endmodule

// File: tb/tb_fifo_trig_ctrl.sv
module tb_fifo_trig_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       fcr_wr, enh_tx_trig;
  logic [7:0] fcr_data;
  logic       tx_push, tx_pop, rx_push, rx_pop;
  logic [7:0] tx_din, rx_din, tx_dout, rx_dout;
  logic [5:0] tx_count, rx_count;
  logic       tx_req, rx_req, tx_ovr, rx_ovr;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_trig_ctrl dut (
    .clk(clk), .rst(rst), .fcr_wr(fcr_wr), .fcr_data(fcr_data), .enh_tx_trig(enh_tx_trig),
    .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .tx_count(tx_count), .tx_req(tx_req), .tx_ovr(tx_ovr),
    .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
    .rx_count(rx_count), .rx_req(rx_req), .rx_ovr(rx_ovr)
  );

  // reference model state
  logic [7:0] txq[$], rxq[$];
  logic       m_qmode, m_tovr, m_rovr;
  logic [1:0] m_rxc, m_txc;
  logic [7:0] m_tdout, m_rdout;
  logic       m_treq, m_rreq;

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 24;
      default: return 28;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic side_step(ref logic [7:0] q[$], ref logic ovr, ref logic [7:0] dq,
                           input logic flush, input int cap,
                           input logic push, input logic [7:0] din, input logic pop);
    bit full;
    if (flush) begin
      q.delete();
      ovr = 1'b0;
    end else begin
      full = (q.size() == cap);
      if (pop && q.size() != 0) dq = q.pop_front();
      if (push) begin
        if (full) ovr = 1'b1;
        else q.push_back(din);
      end
    end
  endtask

  // one clock: drive at negedge, update model, check after the edge
  task automatic cyc(input string tag, input logic wr, input logic [7:0] d, input logic enh,
                     input logic tp, input logic [7:0] td, input logic tpo,
                     input logic rp, input logic [7:0] rd, input logic rpo);
    int  cap, tlev, rlev;
    bit  hold, chg;
    fcr_wr = wr; fcr_data = d; enh_tx_trig = enh;
    tx_push = tp; tx_din = td; tx_pop = tpo;
    rx_push = rp; rx_din = rd; rx_pop = rpo;
    hold = !m_qmode;
    cap  = hold ? 1 : 32;
    tlev = enh ? lvl(m_txc) : 16;
    rlev = lvl(m_rxc);
    chg  = wr && (d[0] != m_qmode);
    side_step(txq, m_tovr, m_tdout, wr && (d[2] || chg), cap, tp, td, tpo);
    side_step(rxq, m_rovr, m_rdout, wr && (d[1] || chg), cap, rp, rd, rpo);
    m_treq = hold ? (txq.size() == 0) : (txq.size() <= tlev);
    m_rreq = hold ? (rxq.size() != 0) : (rxq.size() >= rlev);
    if (wr) begin
      m_qmode = d[0]; m_txc = d[5:4]; m_rxc = d[7:6];
    end
    @(posedge clk);
    #1;
    check(tag, "tx_count", int'(tx_count), txq.size());
    check(tag, "rx_count", int'(rx_count), rxq.size());
    check(tag, "tx_req", int'(tx_req), int'(m_treq));
    check(tag, "rx_req", int'(rx_req), int'(m_rreq));
    check(tag, "tx_ovr", int'(tx_ovr), int'(m_tovr));
    check(tag, "rx_ovr", int'(rx_ovr), int'(m_rovr));
    check(tag, "tx_dout", int'(tx_dout), int'(m_tdout));
    check(tag, "rx_dout", int'(rx_dout), int'(m_rdout));
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input logic enh);
    cyc(tag, 1'b0, 8'h00, enh, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    fcr_wr = 0; fcr_data = 0; enh_tx_trig = 0;
    tx_push = 0; tx_din = 0; tx_pop = 0; rx_push = 0; rx_din = 0; rx_pop = 0;
    m_qmode = 0; m_rxc = 0; m_txc = 1; m_tovr = 0; m_rovr = 0;
    m_tdout = 0; m_rdout = 0; m_treq = 1; m_rreq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "tx_count", int'(tx_count), 0);
    check("R1", "rx_count", int'(rx_count), 0);
    check("R1", "tx_req", int'(tx_req), 1);
    check("R1", "rx_req", int'(rx_req), 0);
    check("R1", "ovr", int'(tx_ovr | rx_ovr), 0);
    check("R1", "dout", int'(tx_dout | rx_dout), 0);

    // R7 holding mode, R9 overrun at capacity 1, R10 pop of empty
    cyc("R7", 0, 8'h00, 0, 1, 8'h3C, 0, 1, 8'hA5, 0);
    check("R7", "rx_req held", int'(rx_req), 1);
    check("R7", "tx_req held", int'(tx_req), 0);
    cyc("R9", 0, 8'h00, 0, 0, 8'h00, 0, 1, 8'h11, 0);
    check("R9", "rx_ovr", int'(rx_ovr), 1);
    cyc("R3", 0, 8'h00, 0, 1, 8'h00, 1, 0, 8'h00, 1);
    check("R3", "rx_dout", int'(rx_dout), 8'hA5);
    cyc("R10", 0, 8'h00, 0, 0, 8'h00, 0, 0, 8'h00, 1);
    check("R10", "rx_dout kept", int'(rx_dout), 8'hA5);
    check("R10", "rx_count", int'(rx_count), 0);

    // R2 switch to queue mode flushes and clears overrun; rx code 11, tx code 11
    cyc("R2", 1, 8'hF1, 0, 0, 8'h00, 0, 0, 8'h00, 0);
    check("R2", "rx_ovr cleared", int'(rx_ovr), 0);
    check("R2", "tx_count", int'(tx_count), 0);

    // R5: fill tx to 20 with enhanced off (level 16), then on (level 28)
    for (int i = 0; i < 20; i++) cyc("R5", 0, 8'h00, 0, 1, 8'(i), 0, 1, 8'(i + 100), 0);
    idle("R5", 0);
    check("R5", "tx_req fixed 16", int'(tx_req), 0);
    check("R4", "rx_req below 28", int'(rx_req), 0);
    idle("R6", 1);
    check("R5", "tx_req stored 28", int'(tx_req), 1);
    // fill both past capacity
    for (int i = 0; i < 14; i++) cyc("R9", 0, 8'h00, 1, 1, 8'(i + 50), 0, 1, 8'(i + 150), 0);
    check("R4", "rx_req at 28+", int'(rx_req), 1);
    check("R9", "tx_ovr", int'(tx_ovr), 1);
    check("R9", "tx_count full", int'(tx_count), 32);
    // R11 push and pop at full
    cyc("R11", 0, 8'h00, 1, 1, 8'hEE, 1, 1, 8'hEE, 1);
    check("R11", "tx_count", int'(tx_count), 31);
    cyc("R11", 0, 8'h00, 1, 1, 8'h77, 1, 1, 8'h78, 1);
    check("R11", "rx_count", int'(rx_count), 31);
    // R8 flush only receive side
    cyc("R8", 1, 8'hF3, 1, 0, 8'h00, 0, 0, 8'h00, 0);
    check("R8", "rx_count", int'(rx_count), 0);
    check("R8", "tx_count kept", int'(tx_count), 31);
    check("R8", "tx_ovr kept", int'(tx_ovr), 1);
    cyc("R8", 1, 8'h35, 1, 1, 8'h01, 0, 0, 8'h00, 0);
    check("R8", "tx_count", int'(tx_count), 0);

    // random phases, checked every cycle against the model (R3, R4, R5, R6, R9, R11)
    for (int ph = 0; ph < 24; ph++) begin
      int pp = (ph % 2 == 0) ? 75 : 25;
      for (int k = 0; k < 150; k++) begin
        logic       wr = ($urandom % 100) < 3;
        logic [7:0] d  = 8'($urandom);
        logic       enh = enh_tx_trig;
        if (($urandom % 100) < 3) enh = ~enh;
        d[0] = (($urandom % 10) != 0);
        if (($urandom % 5) != 0) d[2:1] = 2'b00;
        cyc("R6", wr, d, enh,
            ($urandom % 100) < pp, 8'($urandom), ($urandom % 100) >= pp,
            ($urandom % 100) < pp, 8'($urandom), ($urandom % 100) >= pp);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule